// File: doc/BRIEF.md
# Router Output-Channel Synchronizer

This block is the glue between a packet router's control state machine and a bank of three output FIFOs that one input port feeds. When the controller allows address capture and a packet is marked valid, the block takes the destination channel from the low bits of the incoming byte. It keeps that channel until the next capture. The controller's single write strobe is then steered to the FIFO of the held channel only. The same held channel selects which FIFO's full and empty flags are reported back to the controller.

Each channel also gets a valid output for its downstream reader. A per-channel idle timer watches for a valid output that nobody reads. After 29 consecutive unread cycles the timer pulses that channel's FIFO soft reset for one cycle.

The timer is a two-state machine. In WATCH it counts idle cycles. The transition WATCH->FIRE is taken on the 29th consecutive idle cycle. FIRE drives the soft-reset pulse, and FIRE->WATCH is always taken one cycle later. In WATCH, a cycle that is not idle clears the count and stays in WATCH.

Top module: `rsync_top`

## Requirements
- R1: While rst_n is low at a rising edge, the held channel is cleared to 0, all idle counts are cleared, every timer enters WATCH and all soft_rst_o bits are low.
- R2: At a rising edge where cap_allow_i and pkt_valid_i are both high, the held channel is loaded from din_i[1:0]. It takes effect from the next cycle.
- R3: At a rising edge where cap_allow_i or pkt_valid_i is low, the held channel keeps its value, whatever din_i carries.
- R4: wr_en_o bit k equals wr_req_i when the held channel is k (k in 0..2), and is 0 otherwise. At most one bit is ever high.
- R5: full_o equals full_i bit k when the held channel is k.
- R6: empty_o equals empty_i bit k when the held channel is k.
- R7: vld_o bit k is the inverse of empty_i bit k, combinationally, for every channel.
- R8: Held channel code 3 is invalid. It gives wr_en_o = 0, full_o = 0 and empty_o = 0.
- R9: A cycle on channel k is idle when vld_o[k] is high and rd_en_i[k] is low. At the edge that ends the 29th consecutive idle cycle counted in WATCH, the timer enters FIRE. soft_rst_o[k] is then high for exactly the following cycle, and counting restarts from zero after it.
- R10: A cycle in WATCH in which rd_en_i[k] is high or vld_o[k] is low clears the count of channel k. The next 29-cycle window starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_allow_i | input | 1 | Controller permits address capture this cycle |
| pkt_valid_i | input | 1 | Packet byte on din_i is valid |
| din_i | input | 8 | Input byte; bits [1:0] are the destination channel |
| wr_req_i | input | 1 | Controller write-enable request |
| full_i | input | 3 | Full flags of the three FIFOs |
| empty_i | input | 3 | Empty flags of the three FIFOs |
| rd_en_i | input | 3 | Read enables from the downstream readers |
| wr_en_o | output | 3 | One-hot write enable to the selected FIFO |
| full_o | output | 1 | Full flag of the held channel |
| empty_o | output | 1 | Empty flag of the held channel |
| vld_o | output | 3 | Per-channel data-available outputs |
| soft_rst_o | output | 3 | Per-channel FIFO soft-reset pulses |

## Verification
Three results are combinational from the current inputs and the held channel: wr_en_o, full_o/empty_o and vld_o. The bench checks them in the same cycle as the stimulus, one nanosecond after inputs change at the falling edge. A capture changes the routing from the cycle after its rising edge. soft_rst_o rises in the cycle after the edge that closes the 29th idle cycle. The bench reference model advances its state only at each rising edge and predicts outputs for the following half-cycle. It therefore compares every output in the exact cycle it is due.

// File: rtl/rsync_pkg.sv
package rsync_pkg;
    localparam int unsigned NUM_CH    = 3;
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned IDLE_LIM  = 29;

    typedef enum logic {
        T_WATCH = 1'b0,
        T_FIRE  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/rsync_addr_hold.sv
module rsync_addr_hold #(
    parameter int unsigned ADDR_W = rsync_pkg::ADDR_W,
    parameter int unsigned BYTE_W = rsync_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_allow_i,
    input  logic              pkt_valid_i,
    input  logic [BYTE_W-1:0] din_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic              load;
    logic [ADDR_W-1:0] addr_q;

    assign load   = cap_allow_i & pkt_valid_i;
    assign addr_o = addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= din_i[ADDR_W-1:0];
    end

    // R3: without both capture qualifiers the held channel does not move
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_allow_i && pkt_valid_i) |=> $stable(addr_q));

    // R2: a qualified capture lands the byte's channel bits
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_allow_i && pkt_valid_i) |=> (addr_q == $past(din_i[ADDR_W-1:0])));
endmodule

// File: rtl/rsync_route.sv
module rsync_route #(
    parameter int unsigned NUM_CH = rsync_pkg::NUM_CH,
    parameter int unsigned ADDR_W = rsync_pkg::ADDR_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_req_i,
    input  logic [NUM_CH-1:0] full_i,
    input  logic [NUM_CH-1:0] empty_i,
    output logic [NUM_CH-1:0] wr_en_o,
    output logic              full_o,
    output logic              empty_o,
    output logic [NUM_CH-1:0] vld_o
);
    logic [NUM_CH-1:0] sel;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        assign sel[k]     = (addr_i == ADDR_W'(k));
        assign wr_en_o[k] = wr_req_i & sel[k];
        assign vld_o[k]   = ~empty_i[k];
    end

    always_comb begin
        full_o  = 1'b0;
        empty_o = 1'b0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (sel[k]) begin
                full_o  = full_i[k];
                empty_o = empty_i[k];
            end
        end
    end

    // R4: never more than one FIFO written, and only on request
    always_comb begin
        assert_onehot_wr_R4: assert ($onehot0(wr_en_o));
        if (!wr_req_i) assert_wr_needs_req_R4: assert (wr_en_o == '0);
    end
endmodule

// File: rtl/rsync_idle_timer.sv
module rsync_idle_timer #(
    parameter int unsigned IDLE_LIM = rsync_pkg::IDLE_LIM,
    localparam int unsigned CNT_W   = $clog2(IDLE_LIM + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic rd_en_i,
    output logic soft_rst_o
);
    import rsync_pkg::*;

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             idle;
    logic             at_lim;

    assign idle   = vld_i & ~rd_en_i;
    assign at_lim = (cnt_q == CNT_W'(IDLE_LIM - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T_WATCH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        cnt_d      = '0;
        soft_rst_o = 1'b0;
        unique case (state_q)
            T_WATCH: begin
                if (idle) begin
                    if (at_lim) state_d = T_FIRE;
                    else        cnt_d   = cnt_q + 1'b1;
                end
            end
            T_FIRE: begin
                soft_rst_o = 1'b1;
                state_d    = T_WATCH;
            end
            default: state_d = T_WATCH;
        endcase
    end

    // R9: the soft reset is a single-cycle pulse
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    // R10: a read while watching restarts the count
    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_WATCH && rd_en_i) |=> (cnt_q == '0));

    // R9: a pulse only follows an idle cycle at the limit
    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst_o) |-> $past(idle && at_lim));
endmodule

// File: rtl/rsync_top.sv
module rsync_top #(
    parameter int unsigned NUM_CH   = rsync_pkg::NUM_CH,
    parameter int unsigned ADDR_W   = rsync_pkg::ADDR_W,
    parameter int unsigned BYTE_W   = rsync_pkg::BYTE_W,
    parameter int unsigned IDLE_LIM = rsync_pkg::IDLE_LIM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_allow_i,
    input  logic              pkt_valid_i,
    input  logic [BYTE_W-1:0] din_i,
    input  logic              wr_req_i,
    input  logic [NUM_CH-1:0] full_i,
    input  logic [NUM_CH-1:0] empty_i,
    input  logic [NUM_CH-1:0] rd_en_i,
    output logic [NUM_CH-1:0] wr_en_o,
    output logic              full_o,
    output logic              empty_o,
    output logic [NUM_CH-1:0] vld_o,
    output logic [NUM_CH-1:0] soft_rst_o
);
    logic [ADDR_W-1:0] addr;

    rsync_addr_hold #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_allow_i(cap_allow_i),
        .pkt_valid_i(pkt_valid_i),
        .din_i      (din_i),
        .addr_o     (addr)
    );

    rsync_route #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_route (
        .addr_i  (addr),
        .wr_req_i(wr_req_i),
        .full_i  (full_i),
        .empty_i (empty_i),
        .wr_en_o (wr_en_o),
        .full_o  (full_o),
        .empty_o (empty_o),
        .vld_o   (vld_o)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_tmr
        rsync_idle_timer #(.IDLE_LIM(IDLE_LIM)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .vld_i     (vld_o[k]),
            .rd_en_i   (rd_en_i[k]),
            .soft_rst_o(soft_rst_o[k])
        );
    end

    // R8: an out-of-range channel reaches no FIFO and reports no status
    always_comb begin
        if (addr >= ADDR_W'(NUM_CH)) begin
            assert_invalid_quiet_R8: assert (wr_en_o == '0 && !full_o && !empty_o);
        end
    end

    // R1: soft resets are low in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (soft_rst_o == '0));
endmodule

// File: tb/rsync_top_test.sv
`timescale 1ns/1ps
module rsync_top_test;
    localparam int NCH = 3;
    localparam int LIM = 29;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cap, pv, wr;
    logic [7:0] din;
    logic [2:0] fi, ei, rd;
    logic [2:0] wr_en, vld, srst;
    logic       fo, eo;

    int checks = 0;
    int errors = 0;

    int unsigned m_addr;
    int unsigned m_cnt [NCH];
    bit          m_fire[NCH];

    always #2 clk = ~clk;

    rsync_top uut (
        .clk(clk), .rst_n(rst_n), .cap_allow_i(cap), .pkt_valid_i(pv),
        .din_i(din), .wr_req_i(wr), .full_i(fi), .empty_i(ei), .rd_en_i(rd),
        .wr_en_o(wr_en), .full_o(fo), .empty_o(eo), .vld_o(vld), .soft_rst_o(srst)
    );

    function automatic logic [2:0] exp_wr(int unsigned a, logic req);
        logic [2:0] v = 3'b000;
        if (req && a < NCH) v[a] = 1'b1;
        return v;
    endfunction

    function automatic logic exp_sel(int unsigned a, logic [2:0] flags);
        if (a < NCH) return flags[a];
        return 1'b0;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [2:0] s;
        for (int k = 0; k < NCH; k++) s[k] = m_fire[k];
        if (m_addr == 3) begin
            chk("R8", {5'd0, wr_en}, 8'd0);
            chk("R8", {7'd0, fo}, 8'd0);
            chk("R8", {7'd0, eo}, 8'd0);
        end else begin
            chk("R4", {5'd0, wr_en}, {5'd0, exp_wr(m_addr, wr)});
            chk("R5", {7'd0, fo}, {7'd0, exp_sel(m_addr, fi)});
            chk("R6", {7'd0, eo}, {7'd0, exp_sel(m_addr, ei)});
        end
        chk("R7", {5'd0, vld}, {5'd0, ~ei});
        chk("R9", {5'd0, srst}, {5'd0, s});
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_addr = 0;
            for (int k = 0; k < NCH; k++) begin m_cnt[k] = 0; m_fire[k] = 0; end
        end else begin
            if (cap && pv) m_addr = int'(din[1:0]);
            for (int k = 0; k < NCH; k++) begin
                if (m_fire[k]) begin
                    m_fire[k] = 0; m_cnt[k] = 0;
                end else if (!ei[k] && !rd[k]) begin
                    if (m_cnt[k] == LIM - 1) begin m_cnt[k] = 0; m_fire[k] = 1; end
                    else m_cnt[k]++;
                end else m_cnt[k] = 0;
            end
        end
    endtask

    task automatic cyc(logic c, logic p, logic [7:0] d, logic w,
                       logic [2:0] f, logic [2:0] e, logic [2:0] r);
        @(negedge clk);
        cap = c; pv = p; din = d; wr = w; fi = f; ei = e; rd = r;
        #1;
        if (rst_n) compare_all();
        @(posedge clk);
        model_edge();
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        rst_n = 1'b0;
        cap = 0; pv = 0; din = 0; wr = 0; fi = 0; ei = 3'b111; rd = 0;
        for (int i = 0; i < 3; i++) cyc(0, 0, 8'h00, 0, 3'b000, 3'b000, 3'b000);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state: channel 0 held, no soft reset, counts at zero
        cyc(0, 0, 8'h00, 1, 3'b001, 3'b111, 3'b000);
        chk("R1", {5'd0, wr_en}, 8'd1);
        chk("R1", {5'd0, srst}, 8'd0);

        // R2: capture channel 2, effective the next cycle
        cyc(1, 1, 8'hF6, 1, 3'b100, 3'b111, 3'b000);
        chk("R2", {5'd0, wr_en}, 8'd1);
        cyc(0, 0, 8'h00, 1, 3'b100, 3'b011, 3'b000);
        chk("R2", {5'd0, wr_en}, 8'd4);
        chk("R5", {7'd0, fo}, 8'd1);
        chk("R6", {7'd0, eo}, 8'd0);

        // R3: capture ignored with only one qualifier
        cyc(1, 0, 8'h01, 1, 3'b000, 3'b111, 3'b000);
        cyc(0, 1, 8'h00, 1, 3'b000, 3'b111, 3'b000);
        cyc(0, 0, 8'h00, 1, 3'b000, 3'b111, 3'b000);
        chk("R3", {5'd0, wr_en}, 8'd4);

        // R8: invalid channel 3
        cyc(1, 1, 8'h03, 0, 3'b000, 3'b111, 3'b000);
        cyc(0, 0, 8'h00, 1, 3'b111, 3'b111, 3'b000);
        chk("R8", {5'd0, wr_en, fo, eo}, 8'd0);

        // R9: exact timeout on channel 1
        for (int i = 0; i < LIM; i++) begin
            cyc(0, 0, 8'h00, 0, 3'b000, 3'b101, 3'b000);
            chk("R9", {5'd0, srst}, 8'd0);
        end
        cyc(0, 0, 8'h00, 0, 3'b000, 3'b101, 3'b000);
        chk("R9", {5'd0, srst}, 8'd2);
        cyc(0, 0, 8'h00, 0, 3'b000, 3'b101, 3'b000);
        chk("R9", {5'd0, srst}, 8'd0);

        // R10: a read just before the limit restarts the window
        for (int i = 0; i < 60; i++) cyc(0, 0, 8'h00, 0, 3'b000, 3'b111, 3'b000);
        for (int i = 0; i < LIM - 1; i++) cyc(0, 0, 8'h00, 0, 3'b000, 3'b110, 3'b000);
        cyc(0, 0, 8'h00, 0, 3'b000, 3'b110, 3'b001);
        for (int i = 0; i < LIM - 1; i++) begin
            cyc(0, 0, 8'h00, 0, 3'b000, 3'b110, 3'b000);
            chk("R10", {5'd0, srst}, 8'd0);
        end

        // random phases with varying read density
        for (int ph = 0; ph < 8; ph++) begin
            int unsigned rdpct = (ph % 4) * 3;
            for (int i = 0; i < 400; i++) begin
                logic [2:0] r3, e3;
                for (int k = 0; k < NCH; k++) begin
                    r3[k] = (($urandom % 100) < rdpct);
                    e3[k] = (($urandom % 100) < 5);
                end
                cyc(($urandom % 8) == 0, $urandom % 2, 8'($urandom), $urandom % 2,
                    3'($urandom), e3, r3);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule